// File: doc/BRIEF.md
# BCD Real-Time Clock Register Block

This block keeps wall-clock time and a calendar for a chip, holding every time field as a packed BCD byte. The tens digit sits in bits 7:4 and the units digit in bits 3:0. A prescaled tick strobe from the board oscillator drives an internal divider. The divider produces one seconds event per `TICK_HZ` ticks. Each unmasked seconds event moves the time forward by one second, carrying through minutes, hours, the weekday, the day of the month, the month and a two-digit year. The day of the month follows each month's length and the four-year leap rule.

Software uses a byte-wide register port with separate read and write strobes. Seven time fields sit at the low addresses, followed by two control registers and two status registers. The divider can be held in reset through a select field. Time can be frozen for setting through a freeze bit. A periodic interrupt pulse, derived from the same tick, can be switched on and off. A status bit toggles on every read of the first control register, so that polling software always sees it change.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x07, day 0x01, month 0x01 and year 0x00. Control A reads 0x26 on its bits 6:0, control B reads 0x42 (bit 6 periodic enable set, bit 1 for 24-hour mode set, bit 2 for BCD mode clear), and no interrupt pulse is produced before the first tick.
- R2: The addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 control A, 8 control B, 9 status C and 10 status D. A write stores the whole byte. A read asserted in one cycle presents the addressed byte on `rdata_o` from the next cycle on, and `rdata_o` holds it until the next read.
- R3: While the divider runs, every `TICK_HZ`-th tick is a seconds event. Seconds and minutes wrap 0x59 to 0x00 and hours wrap 0x23 to 0x00, each wrap carrying into the next field.
- R4: The day of the month wraps to 0x01 after 0x31, or after 0x30 in months 0x04, 0x06, 0x09 and 0x11. In month 0x02 it wraps after 0x29 when the year is divisible by 4, and after 0x28 otherwise. Month 0x12 wraps to 0x01 and carries into the year, which wraps 0x99 to 0x00.
- R5: The weekday advances on every day rollover and wraps from 0x07 to 0x01.
- R6: Control A bits 6:4 select the divider. The codes 3'b110 and 3'b111 hold it in reset, and no seconds event occurs while either is selected. After a hold code is replaced by any other code, the first seconds event comes `TICK_HZ/2` ticks later and the following ones come every `TICK_HZ` ticks.
- R7: While control B bit 7 (freeze) is 1, seconds events leave all time fields unchanged.
- R8: Control A bit 7 is read-only, and writes do not change it. Each read of control A inverts it and returns the inverted value, so two back-to-back reads return opposite values in bit 7.
- R9: Status C and D, and every address above 10, read 0x00. Writes to those addresses change nothing.
- R10: While control B bit 6 is 1, `irq_o` pulses high for one cycle on every `PIE_DIV`-th tick. When the bit is 0, `irq_o` stays low and the interrupt count restarts.
- R11: A bus write to a time field in the same cycle as a seconds event stores the written value in that field instead of the incremented one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled oscillator strobe, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Periodic interrupt pulse |

## Verification
The bench sets the calendar to each month-end boundary while time is frozen, releases the freeze and lets one seconds event occur. It covers February in a leap year and in a common year, a 30-day month, and the year-end wrap from 99 to 00. A wrong month-length decode or leap test would show up as a day 0x29, 0x31 or 0x32 where day 0x01 or 0x29 is expected. The divider is released from its hold code while the seconds field is polled. A design that restarted the divider at zero would advance a half period late, and the bench sees that. A write is placed in the exact cycle of a seconds event, which catches an increment that wins over the write. Back-to-back reads of control A catch a status bit that only toggles on some reads or that a write can change. Turning the interrupt enable off and on catches pulses that leak through while it is off, or that come at the wrong spacing.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

   localparam int NUM_FIELDS = 7;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HOUR = 2;
   localparam int F_WDAY = 3;
   localparam int F_MDAY = 4;
   localparam int F_MON  = 5;
   localparam int F_YEAR = 6;
   localparam int REG_CTLA = 7;
   localparam int REG_CTLB = 8;
   localparam int REG_STSC = 9;
   localparam int REG_STSD = 10;
   localparam int NUM_REGS = 11;

   localparam logic [6:0] CTLA_RESET = 7'h26;
   localparam logic [7:0] CTLB_RESET = 8'h42;
   localparam int CTLB_FREEZE = 7;
   localparam int CTLB_PIE    = 6;

   typedef logic [7:0] bcd_t;
   typedef bcd_t [NUM_FIELDS-1:0] tfields_t;

   // power-on calendar
   function automatic tfields_t fields_reset();
      tfields_t f;
      f[F_SEC]  = 8'h00;
      f[F_MIN]  = 8'h00;
      f[F_HOUR] = 8'h00;
      f[F_WDAY] = 8'h07;
      f[F_MDAY] = 8'h01;
      f[F_MON]  = 8'h01;
      f[F_YEAR] = 8'h00;
      return f;
   endfunction

   // next BCD value, wrapping from last to first
   function automatic bcd_t bcd_step(bcd_t v, bcd_t last, bcd_t first);
      if (v == last)
         return first;
      else if (v[3:0] == 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      else
         return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // two-digit BCD year divisible by four
   function automatic logic bcd_leap(bcd_t y);
      if (!y[4])
         return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
      else
         return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
   endfunction

   // last day of a BCD month
   function automatic bcd_t bcd_month_end(bcd_t mon, bcd_t year);
      case (mon)
         8'h02:                      return bcd_leap(year) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic div_held(logic [2:0] sel);
      return sel[2] & sel[1];
   endfunction

endpackage

// File: rtl/rtc_bcd_prescaler.sv
module rtc_bcd_prescaler #(
   parameter int TICK_HZ = 32768
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic run_i,
   output logic sec_o
);
   localparam int CNT_W = (TICK_HZ > 2) ? $clog2(TICK_HZ) : 1;
   localparam logic [CNT_W-1:0] TOP  = CNT_W'(TICK_HZ - 1);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(TICK_HZ / 2);

   logic [CNT_W-1:0] cnt_q;
   logic             at_top;

   assign at_top = (cnt_q == TOP);
   assign sec_o  = run_i & tick_i & at_top;

   // held at the half point so a release yields a half-period first second
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (!run_i)
         cnt_q <= HALF;
      else if (tick_i)
         cnt_q <= at_top ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/rtc_bcd_periodic.sv
module rtc_bcd_periodic #(
   parameter int PIE_DIV = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic en_i,
   output logic irq_o
);
   localparam int  PW   = (PIE_DIV > 2) ? $clog2(PIE_DIV) : 1;
   localparam bit  POW2 = ((PIE_DIV & (PIE_DIV - 1)) == 0);

   logic [PW-1:0] cnt_q;
   logic          hit;

   generate
      if (POW2) begin : g_pow2
         assign hit = &cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               cnt_q <= '0;
            else if (!en_i)
               cnt_q <= '0;
            else if (tick_i)
               cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_cmp
         assign hit = (cnt_q == PW'(PIE_DIV - 1));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               cnt_q <= '0;
            else if (!en_i)
               cnt_q <= '0;
            else if (tick_i)
               cnt_q <= hit ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         irq_o <= 1'b0;
      else
         irq_o <= en_i & tick_i & hit;
   end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_bcd_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              adv_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output tfields_t          time_o
);
   tfields_t cur_q, step_d, nxt_d;
   logic     c_min, c_hour, c_day, c_mon, c_year;
   bcd_t     eom;

   assign eom    = bcd_month_end(cur_q[F_MON], cur_q[F_YEAR]);
   assign c_min  = cur_q[F_SEC] == 8'h59;
   assign c_hour = c_min  & (cur_q[F_MIN]  == 8'h59);
   assign c_day  = c_hour & (cur_q[F_HOUR] == 8'h23);
   assign c_mon  = c_day  & (cur_q[F_MDAY] == eom);
   assign c_year = c_mon  & (cur_q[F_MON]  == 8'h12);

   // carry chain evaluated on the pre-increment values
   always_comb begin
      step_d = cur_q;
      if (adv_i) begin
         step_d[F_SEC] = bcd_step(cur_q[F_SEC], 8'h59, 8'h00);
         if (c_min)  step_d[F_MIN]  = bcd_step(cur_q[F_MIN],  8'h59, 8'h00);
         if (c_hour) step_d[F_HOUR] = bcd_step(cur_q[F_HOUR], 8'h23, 8'h00);
         if (c_day) begin
            step_d[F_WDAY] = bcd_step(cur_q[F_WDAY], 8'h07, 8'h01);
            step_d[F_MDAY] = bcd_step(cur_q[F_MDAY], eom,   8'h01);
         end
         if (c_mon)  step_d[F_MON]  = bcd_step(cur_q[F_MON],  8'h12, 8'h01);
         if (c_year) step_d[F_YEAR] = bcd_step(cur_q[F_YEAR], 8'h99, 8'h00);
      end
   end

   // a bus write overrides the stepped value of its own field
   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         assign nxt_d[i] = (wr_en_i && addr_i == ADDR_W'(i)) ? wdata_i : step_d[i];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cur_q <= fields_reset();
      else
         cur_q <= nxt_d;
   end

   assign time_o = cur_q;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
   import rtc_bcd_pkg::*;
#(
   parameter int TICK_HZ = 32768,
   parameter int PIE_DIV = 32,
   parameter int ADDR_W  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   output logic              irq_o
);
   localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(REG_CTLA);
   localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(REG_CTLB);

   generate
      if (TICK_HZ < 4 || (TICK_HZ % 2) != 0) begin : g_bad_tick
         $error("TICK_HZ must be even and at least 4");
      end
      if (PIE_DIV < 2) begin : g_bad_pie
         $error("PIE_DIV must be at least 2");
      end
      if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [6:0] ctla_q;
   logic       uip_q;
   logic [7:0] ctlb_q;
   logic       div_run, sec_tick, adv;
   logic       rd_ctla;
   tfields_t   time_q;
   logic [7:0] rd_mux;

   assign div_run = !div_held(ctla_q[6:4]);
   assign adv     = sec_tick & ~ctlb_q[CTLB_FREEZE];
   assign rd_ctla = rd_en_i && (addr_i == A_CTLA);

   rtc_bcd_prescaler #(.TICK_HZ(TICK_HZ)) u_pre (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .run_i (div_run),
      .sec_o (sec_tick)
   );

   rtc_bcd_calendar #(.ADDR_W(ADDR_W)) u_cal (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (adv),
      .wr_en_i(wr_en_i),
      .addr_i (addr_i),
      .wdata_i(wdata_i),
      .time_o (time_q)
   );

   rtc_bcd_periodic #(.PIE_DIV(PIE_DIV)) u_pie (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .en_i  (ctlb_q[CTLB_PIE]),
      .irq_o (irq_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctla_q <= CTLA_RESET;
         ctlb_q <= CTLB_RESET;
      end else if (wr_en_i) begin
         if (addr_i == A_CTLA) ctla_q <= wdata_i[6:0];
         if (addr_i == A_CTLB) ctlb_q <= wdata_i;
      end
   end

   // read-only status bit, flipped by every read of control A
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         uip_q <= 1'b0;
      else if (rd_ctla)
         uip_q <= ~uip_q;
   end

   always_comb begin
      rd_mux = 8'h00;
      for (int i = 0; i < NUM_FIELDS; i++)
         if (addr_i == ADDR_W'(i)) rd_mux = time_q[i];
      if (addr_i == A_CTLA) rd_mux = {~uip_q, ctla_q};
      if (addr_i == A_CTLB) rd_mux = ctlb_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         rdata_o <= 8'h00;
      else if (rd_en_i)
         rdata_o <= rd_mux;
   end
endmodule

// File: rtl/rtc_bcd_checker.sv
module rtc_bcd_checker
   import rtc_bcd_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              rd_en_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [7:0]        wdata_i,
   input logic [7:0]        rdata_i,
   input logic              irq_i,
   input logic              uip_i,
   input logic              pie_i,
   input logic              freeze_i,
   input logic              run_i,
   input logic              sec_i,
   input tfields_t          time_i
);
   logic rd_sts, rd_ctla, step, day_end;
   assign rd_sts  = rd_en_i && (addr_i == ADDR_W'(REG_STSC) || addr_i == ADDR_W'(REG_STSD));
   assign rd_ctla = rd_en_i && (addr_i == ADDR_W'(REG_CTLA));
   assign step    = sec_i && !freeze_i && !wr_en_i;
   assign day_end = time_i[F_SEC] == 8'h59 && time_i[F_MIN] == 8'h59 && time_i[F_HOUR] == 8'h23;

   p_sts_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_sts |=> rdata_i == 8'h00);

   p_uip_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_ctla |=> uip_i != $past(uip_i));

   p_uip_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_ctla |=> $stable(uip_i));

   p_held_no_sec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> !sec_i);

   p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      freeze_i && !wr_en_i |=> $stable(time_i));

   p_irq_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |-> $past(pie_i));

   p_irq_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |=> !irq_i);

   p_sec_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step && time_i[F_SEC] == 8'h59 |=> time_i[F_SEC] == 8'h00);

   p_wday_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step && day_end && time_i[F_WDAY] == 8'h07 |=> time_i[F_WDAY] == 8'h01);

   p_wr_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == ADDR_W'(F_SEC) |=> time_i[F_SEC] == $past(wdata_i));
endmodule

bind rtc_bcd_core rtc_bcd_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .rd_en_i (rd_en_i),
   .wr_en_i (wr_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .rdata_i (rdata_o),
   .irq_i   (irq_o),
   .uip_i   (uip_q),
   .pie_i   (ctlb_q[6]),
   .freeze_i(ctlb_q[7]),
   .run_i   (div_run),
   .sec_i   (sec_tick),
   .time_i  (time_q)
);

// File: tb/rtc_bcd_core_tb.sv
`timescale 1ns/1ps
module rtc_bcd_core_tb_top;
   localparam int TICK_HZ = 16;
   localparam int PIE_DIV = 4;
   localparam int ADDR_W  = 4;

   logic              clk_i = 1'b0;
   logic              rst_ni = 1'b0;
   logic              tick_i = 1'b0;
   logic              wr_en_i = 1'b0;
   logic              rd_en_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [7:0]        wdata_i = 8'h00;
   logic [7:0]        rdata_o;
   logic              irq_o;

   always #10 clk_i = ~clk_i;

   rtc_bcd_core #(.TICK_HZ(TICK_HZ), .PIE_DIV(PIE_DIV), .ADDR_W(ADDR_W)) dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .irq_o(irq_o)
   );

   int    n_vec = 0;
   int    n_err = 0;
   string cur_req = "R1";
   int    tick_sel = 0;
   bit    done = 0;

   // behavioural reference model, integer calendar
   int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year;
   int m_a, m_b, m_uip, m_cnt, m_pcnt, m_irq, m_rdata;

   function automatic int to_bcd(int v);
      return ((v / 10) << 4) | (v % 10);
   endfunction
   function automatic int from_bcd(int v);
      return ((v >> 4) & 15) * 10 + (v & 15);
   endfunction
   function automatic int month_days(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic int m_read(int a);
      case (a)
         0: return to_bcd(m_sec);
         1: return to_bcd(m_min);
         2: return to_bcd(m_hour);
         3: return to_bcd(m_wday);
         4: return to_bcd(m_mday);
         5: return to_bcd(m_mon);
         6: return to_bcd(m_year);
         8: return m_b;
         default: return 0;
      endcase
   endfunction

   task automatic m_second();
      m_sec++;
      if (m_sec < 60) return;
      m_sec = 0; m_min++;
      if (m_min < 60) return;
      m_min = 0; m_hour++;
      if (m_hour < 24) return;
      m_hour = 0;
      m_wday = (m_wday == 7) ? 1 : m_wday + 1;
      m_mday++;
      if (m_mday <= month_days(m_mon, m_year)) return;
      m_mday = 1; m_mon++;
      if (m_mon <= 12) return;
      m_mon = 1;
      m_year = (m_year + 1) % 100;
   endtask

   always @(posedge clk_i) begin
      if (!rst_ni) begin
         m_sec = 0; m_min = 0; m_hour = 0; m_wday = 7; m_mday = 1; m_mon = 1; m_year = 0;
         m_a = 'h26; m_b = 'h42; m_uip = 0; m_cnt = 0; m_pcnt = 0; m_irq = 0; m_rdata = 0;
      end else begin
         int  old_a, old_b;
         bit  adv;
         old_a = m_a; old_b = m_b; adv = 0;
         if (rd_en_i) begin
            if (addr_i == 7) begin
               m_uip = 1 - m_uip;
               m_rdata = (m_uip << 7) | m_a;
            end else m_rdata = m_read(addr_i);
         end
         if (((old_a >> 4) & 7) >= 6) m_cnt = TICK_HZ / 2;
         else if (tick_i) begin
            if (m_cnt == TICK_HZ - 1) begin m_cnt = 0; adv = ((old_b >> 7) & 1) == 0; end
            else m_cnt++;
         end
         m_irq = 0;
         if (((old_b >> 6) & 1) == 0) m_pcnt = 0;
         else if (tick_i) begin
            if (m_pcnt == PIE_DIV - 1) begin m_pcnt = 0; m_irq = 1; end
            else m_pcnt++;
         end
         if (adv) m_second();
         if (wr_en_i) begin
            case (addr_i)
               0: m_sec  = from_bcd(wdata_i);
               1: m_min  = from_bcd(wdata_i);
               2: m_hour = from_bcd(wdata_i);
               3: m_wday = from_bcd(wdata_i);
               4: m_mday = from_bcd(wdata_i);
               5: m_mon  = from_bcd(wdata_i);
               6: m_year = from_bcd(wdata_i);
               7: m_a    = wdata_i & 'h7f;
               8: m_b    = wdata_i;
               default: ;
            endcase
         end
      end
   end

   // compare on every falling edge
   always @(negedge clk_i) begin
      if (rst_ni && !done) begin
         n_vec++;
         if (rdata_o !== 8'(m_rdata)) begin
            n_err++;
            $display("FAIL %s rdata got %h exp %h at %0t", cur_req, rdata_o, 8'(m_rdata), $time);
         end
         n_vec++;
         if (irq_o !== 1'(m_irq)) begin
            n_err++;
            $display("FAIL %s irq got %b exp %b at %0t", cur_req, irq_o, 1'(m_irq), $time);
         end
      end
   end

   // tick source: 0 off, 1 every cycle, 2 every third cycle
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk_i);
         ph = (ph + 1) % 3;
         tick_i = (tick_sel == 1) || (tick_sel == 2 && ph == 0);
      end
   end

   task automatic chk(string req, int got, int exp);
      n_vec++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic wr(int a, int d);
      @(negedge clk_i);
      wr_en_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = 8'(d);
      @(negedge clk_i);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(int a, output int v);
      @(negedge clk_i);
      rd_en_i = 1'b1; addr_i = ADDR_W'(a);
      @(negedge clk_i);
      rd_en_i = 1'b0;
      v = rdata_o;
   endtask

   task automatic rd_chk(string req, int a, int exp);
      int v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic set_date(int y, int mo, int d, int wd, int h, int mi, int s);
      wr(8, 'hC2);
      wr(6, y); wr(5, mo); wr(4, d); wr(3, wd); wr(2, h); wr(1, mi); wr(0, s);
      wr(8, 'h42);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk_i);
   endtask

   initial begin
      int v1, v2, pulses;
      idle(3);
      rst_ni = 1'b1;

      // R1: reset contents
      cur_req = "R1";
      rd_chk("R1 sec", 0, 'h00);
      rd_chk("R1 wday", 3, 'h07);
      rd_chk("R1 mday", 4, 'h01);
      rd_chk("R1 mon", 5, 'h01);
      rd_chk("R1 year", 6, 'h00);
      rd(7, v1); chk("R1 ctla", v1 & 'h7f, 'h26);
      rd_chk("R1 ctlb", 8, 'h42);

      // R2: map and storage
      cur_req = "R2";
      wr(8, 'hC2);
      wr(1, 'h37); wr(2, 'h12); wr(6, 'h75);
      rd_chk("R2 min", 1, 'h37);
      rd_chk("R2 hour", 2, 'h12);
      rd_chk("R2 year", 6, 'h75);
      wr(8, 'h42);

      // R3: time rollover, sparse ticks
      cur_req = "R3";
      tick_sel = 2;
      set_date('h24, 'h06, 'h10, 'h02, 'h23, 'h59, 'h58);
      idle(200);
      rd_chk("R3 hour", 2, 'h00);
      rd_chk("R3 min", 1, 'h00);
      tick_sel = 1;

      // R4: month lengths and leap years
      cur_req = "R4";
      set_date('h23, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59);
      idle(TICK_HZ + 2);
      rd_chk("R4 common feb day", 4, 'h01);
      rd_chk("R4 common feb mon", 5, 'h03);
      set_date('h24, 'h02, 'h28, 'h03, 'h23, 'h59, 'h59);
      idle(TICK_HZ + 2);
      rd_chk("R4 leap feb day", 4, 'h29);
      rd_chk("R4 leap feb mon", 5, 'h02);
      set_date('h24, 'h04, 'h30, 'h03, 'h23, 'h59, 'h59);
      idle(TICK_HZ + 2);
      rd_chk("R4 april end", 4, 'h01);
      rd_chk("R4 april mon", 5, 'h05);
      set_date('h99, 'h12, 'h31, 'h07, 'h23, 'h59, 'h59);
      idle(TICK_HZ + 2);
      rd_chk("R4 year wrap", 6, 'h00);
      rd_chk("R4 month wrap", 5, 'h01);
      // R5: weekday 7 -> 1 on the same rollover
      cur_req = "R5";
      rd_chk("R5 wday", 3, 'h01);

      // R7: freeze
      cur_req = "R7";
      wr(8, 'hC2);
      rd(0, v1);
      idle(3 * TICK_HZ);
      rd_chk("R7 frozen sec", 0, v1);
      wr(8, 'h42);

      // R6: divider hold and half-period release
      cur_req = "R6";
      wr(7, 'h66);
      wr(0, 'h10);
      idle(4 * TICK_HZ);
      rd_chk("R6 held", 0, 'h10);
      wr(7, 'h26);
      rd_chk("R6 before half", 0, 'h10);
      idle(10);
      rd_chk("R6 after half", 0, 'h11);
      for (int i = 0; i < TICK_HZ + 4; i++) rd(0, v2);
      wr(7, 'h76);
      idle(2 * TICK_HZ);
      wr(7, 'h26);
      for (int i = 0; i < TICK_HZ + 4; i++) rd(0, v2);

      // R8: read-only toggling status bit
      cur_req = "R8";
      rd(7, v1); rd(7, v2);
      chk("R8 toggle", (v1 ^ v2) & 'h80, 'h80);
      wr(7, 'hA6);
      rd(7, v1); chk("R8 write keeps bit", v1 & 'h80, (v2 & 'h80) ^ 'h80);
      chk("R8 low bits", v1 & 'h7f, 'h26);

      // R9: status registers and unmapped space
      cur_req = "R9";
      rd_chk("R9 C", 9, 'h00);
      rd_chk("R9 D", 10, 'h00);
      wr(9, 'hFF); wr(15, 'hFF);
      rd_chk("R9 C after write", 9, 'h00);
      rd_chk("R9 unmapped", 15, 'h00);

      // R10: periodic interrupt gating and spacing
      cur_req = "R10";
      wr(8, 'h02);
      pulses = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk_i); pulses += irq_o; end
      chk("R10 off", pulses, 0);
      wr(8, 'h42);
      pulses = 0;
      for (int i = 0; i < 8 * PIE_DIV; i++) begin @(negedge clk_i); pulses += irq_o; end
      chk("R10 rate", pulses, 8);

      // R11: write in the cycle of a seconds event
      cur_req = "R11";
      while (m_cnt != TICK_HZ - 1) @(negedge clk_i);
      wr_en_i = 1'b1; addr_i = '0; wdata_i = 8'h42;
      @(negedge clk_i);
      wr_en_i = 1'b0;
      rd_chk("R11 write wins", 0, 'h42);

      idle(4);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         n_err++;
         $display("FAIL %s watchdog expired", cur_req);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   end
endmodule